// File: doc/BRIEF.md
# Big-Endian Byte Lane Load/Store Unit

This block connects a 32-bit processor datapath to a memory that is organised as whole words. For every request it forms the effective byte address from a base value and a signed 16-bit offset. It turns that address into a word index and a lane offset. For a store, it steers the data onto the matching byte lanes and raises only the write-enable bits those lanes need. Lanes are numbered big-endian inside a word: offset 0 is the most significant byte and offset 3 is the least significant.

The memory is treated as synchronous with a one-cycle read latency. A read request issued in one cycle returns its word in the next cycle. In that same next cycle the unit turns the word into the load result. Byte loads are sign-extended, and word loads pass through unchanged. A word access whose effective address is not a multiple of four is reported on a flag and never reaches the memory. Byte accesses at any offset are legal.

Top module: `lane_lsu`

## Requirements
- R1: The effective address is `base_addr` plus `disp_imm` sign-extended to 32 bits, with wraparound modulo 2^32. `mem_word_addr` carries bits 31:2 of that sum.
- R2: A word store (`acc_kind` = 2'b01) at an aligned address sets `mem_wr_en`. It drives `mem_byte_we` to 4'b1111 and `mem_wr_data` to `store_data` unchanged.
- R3: A byte store (`acc_kind` = 2'b11) sets `mem_wr_en` with exactly one bit of `mem_byte_we` high. That bit is bit 3 for offset 0 and bit 0 for offset 3. The low byte of `store_data` appears on data bits 31:24 for offset 0, down to bits 7:0 for offset 3, and every other lane reads zero.
- R4: A word load (`acc_kind` = 2'b00) at an aligned address sets `mem_rd_en`. In the following cycle `load_valid` is high and `load_result` equals `mem_rd_data`.
- R5: A byte load (`acc_kind` = 2'b10) sets `mem_rd_en`. In the following cycle `load_result` is the byte of `mem_rd_data` on the lane chosen by the request's offset, using the same lane mapping as R3, sign-extended to 32 bits.
- R6: A word access whose effective address has nonzero bits 1:0 raises `misalign`. For that access `mem_wr_en` and `mem_rd_en` stay low, `mem_byte_we` is zero, and no load result follows. Byte accesses never raise `misalign`.
- R7: With `req_valid` low, `mem_wr_en`, `mem_rd_en`, `misalign`, `mem_byte_we` and `mem_wr_data` are all zero. In the next cycle `load_valid` is low and `load_result` is zero. The same holds in the cycle after any store.
- R8: While `rst_n` is low, and in the first cycle after it rises, `load_valid` is low and `load_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is requested this cycle |
| acc_kind | input | 2 | 00 word load, 01 word store, 10 byte load, 11 byte store |
| base_addr | input | 32 | Base register value |
| disp_imm | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to be stored |
| mem_word_addr | output | 30 | Word index sent to memory |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_byte_we | output | 4 | Per-lane write enables, bit 3 = most significant lane |
| mem_wr_data | output | 32 | Store word, lane-aligned |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_data | input | 32 | Word returned by memory one cycle after a read |
| misalign | output | 1 | Word access at an unaligned address |
| load_valid | output | 1 | `load_result` holds a finished load |
| load_result | output | 32 | Extracted and extended load value |

## Verification
A wrong lane decode shows up at once, in the request cycle. A store's enable bit or data byte lands on the mirrored lane, for example offset 0 writing bits 7:0. A bad misalignment decision also shows in that cycle, as a write strobe that is raised or suppressed wrongly. The pending-load registers can only be seen one cycle later. If the captured offset or access size is stale or wrong, the load takes the wrong byte or extends the wrong way, and the error appears at the first `load_result` after the read. The sweep covers every access kind at all four offsets, with data chosen so that the sign bit differs between lanes. Because of that, swapping lanes, zero-extending or dropping a strobe each change a checked value.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int ADDR_W  = 32;
  localparam int BYTES   = 4;
  localparam int DATA_W  = 8 * BYTES;
  localparam int OFF_W   = $clog2(BYTES);
  localparam int DISP_W  = 16;
  localparam int WADDR_W = ADDR_W - OFF_W;

  // bit 1 selects byte size, bit 0 selects store
  typedef enum logic [1:0] {
    ACC_LW = 2'b00,
    ACC_SW = 2'b01,
    ACC_LB = 2'b10,
    ACC_SB = 2'b11
  } acc_kind_e;

  function automatic logic [ADDR_W-1:0] calc_eff(
    input logic [ADDR_W-1:0] base,
    input logic [DISP_W-1:0] disp
  );
    return base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  endfunction

  // big-endian: lane with offset g lives at bit position (BYTES-1-g)*8
  function automatic int lane_lsb(input int g);
    return (BYTES - 1 - g) * 8;
  endfunction

  function automatic logic [DATA_W-1:0] sext_byte(input logic [7:0] b);
    return {{(DATA_W-8){b[7]}}, b};
  endfunction
endpackage

// File: rtl/lane_addr_gen.sv
module lane_addr_gen
  import lane_pkg::*;
(
  input  logic                req_valid,
  input  logic [1:0]          acc_kind,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [DISP_W-1:0]   disp_imm,
  output logic [WADDR_W-1:0]  word_addr,
  output logic [OFF_W-1:0]    byte_off,
  output logic                is_store,
  output logic                is_byte,
  output logic                misalign,
  output logic                access_ok
);
  logic [ADDR_W-1:0] eff_addr;

  always_comb begin
    eff_addr  = calc_eff(base_addr, disp_imm);
    word_addr = eff_addr[ADDR_W-1:OFF_W];
    byte_off  = eff_addr[OFF_W-1:0];
    is_store  = acc_kind[0];
    is_byte   = acc_kind[1];
    misalign  = req_valid && !is_byte && (byte_off != '0);
    access_ok = req_valid && !misalign;
  end
endmodule

// File: rtl/lane_store_path.sv
module lane_store_path
  import lane_pkg::*;
(
  input  logic              access_ok,
  input  logic              is_store,
  input  logic              is_byte,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [DATA_W-1:0] store_data,
  output logic              wr_en,
  output logic [BYTES-1:0]  byte_we,
  output logic [DATA_W-1:0] wr_data
);
  logic [BYTES-1:0] lane_hit;

  assign wr_en = access_ok && is_store;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam int LSB = lane_pkg::lane_lsb(g);
    assign lane_hit[g] = wr_en && (!is_byte || (byte_off == OFF_W'(g)));
    assign byte_we[BYTES-1-g] = lane_hit[g];
    assign wr_data[LSB +: 8] = !lane_hit[g] ? 8'h00 :
                               (is_byte ? store_data[7:0] : store_data[LSB +: 8]);
  end
endmodule

// File: rtl/lane_load_path.sv
module lane_load_path
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              is_byte,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_result
);
  logic             pend_valid;
  logic             pend_byte;
  logic [OFF_W-1:0] pend_off;
  logic [7:0]       lane_byte [BYTES];
  logic [7:0]       picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_byte  <= 1'b0;
      pend_off   <= '0;
    end else begin
      pend_valid <= rd_en;
      pend_byte  <= rd_en && is_byte;
      pend_off   <= rd_en ? byte_off : '0;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_byte[g] = mem_rd_data[lane_pkg::lane_lsb(g) +: 8];
  end

  assign picked      = lane_byte[pend_off];
  assign load_valid  = pend_valid;
  assign load_result = !pend_valid ? '0 :
                       (pend_byte ? sext_byte(picked) : mem_rd_data);

  AST_LOAD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> load_valid); // R4
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!load_valid && load_result == '0)); // R7
endmodule

// File: rtl/lane_lsu.sv
module lane_lsu
  import lane_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   acc_kind,
  input  logic [31:0]  base_addr,
  input  logic [15:0]  disp_imm,
  input  logic [31:0]  store_data,
  output logic [29:0]  mem_word_addr,
  output logic         mem_wr_en,
  output logic [3:0]   mem_byte_we,
  output logic [31:0]  mem_wr_data,
  output logic         mem_rd_en,
  input  logic [31:0]  mem_rd_data,
  output logic         misalign,
  output logic         load_valid,
  output logic [31:0]  load_result
);
  logic [OFF_W-1:0] byte_off;
  logic             is_store;
  logic             is_byte;
  logic             access_ok;

  lane_addr_gen u_addr (
    .req_valid (req_valid),
    .acc_kind  (acc_kind),
    .base_addr (base_addr),
    .disp_imm  (disp_imm),
    .word_addr (mem_word_addr),
    .byte_off  (byte_off),
    .is_store  (is_store),
    .is_byte   (is_byte),
    .misalign  (misalign),
    .access_ok (access_ok)
  );

  lane_store_path u_store (
    .access_ok  (access_ok),
    .is_store   (is_store),
    .is_byte    (is_byte),
    .byte_off   (byte_off),
    .store_data (store_data),
    .wr_en      (mem_wr_en),
    .byte_we    (mem_byte_we),
    .wr_data    (mem_wr_data)
  );

  assign mem_rd_en = access_ok && !is_store;

  lane_load_path u_load (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (mem_rd_en),
    .is_byte     (is_byte),
    .byte_off    (byte_off),
    .mem_rd_data (mem_rd_data),
    .load_valid  (load_valid),
    .load_result (load_result)
  );

  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_wr_en && !mem_rd_en && mem_byte_we == 4'b0000)); // R6
  AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && acc_kind == ACC_SB) |-> $countones(mem_byte_we) == 1); // R3
  AST_WORD_STORE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && acc_kind == ACC_SW) |-> mem_byte_we == 4'b1111); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_wr_en && !mem_rd_en && !misalign && mem_byte_we == 4'b0000)); // R7
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en)); // R7
endmodule

// File: tb/test_lane_lsu.sv
`timescale 1ns/100ps
module test_lane_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [31:0] base_addr = '0;
  logic [15:0] disp_imm = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_rd_data = '0;
  logic [29:0] mem_word_addr;
  logic        mem_wr_en;
  logic [3:0]  mem_byte_we;
  logic [31:0] mem_wr_data;
  logic        mem_rd_en;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lane_lsu i_lane_lsu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .base_addr(base_addr), .disp_imm(disp_imm), .store_data(store_data),
    .mem_word_addr(mem_word_addr), .mem_wr_en(mem_wr_en),
    .mem_byte_we(mem_byte_we), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .misalign(misalign),
    .load_valid(load_valid), .load_result(load_result)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic [1:0] k, input logic [31:0] b,
                            input logic [15:0] d, input logic [31:0] sd,
                            input logic [31:0] rw);
    logic [31:0] eff;
    logic [1:0]  off;
    logic        mis, ewr, erd;
    logic [3:0]  emask;
    logic [31:0] edata, eres;
    int          sh;
    @(negedge clk);
    req_valid = 1'b1; acc_kind = k; base_addr = b; disp_imm = d;
    store_data = sd; mem_rd_data = 32'hDEAD_BEEF;
    eff   = b + 32'($signed(d));
    off   = eff[1:0];
    sh    = 8 * (3 - int'(off));
    mis   = !k[1] && (off != 2'd0);
    ewr   = k[0] && !mis;
    erd   = !k[0] && !mis;
    emask = !ewr ? 4'h0 : (k[1] ? (4'b1000 >> off) : 4'hF);
    edata = !ewr ? 32'h0 : (k[1] ? ({24'h0, sd[7:0]} << sh) : sd);
    eres  = !erd ? 32'h0 :
            (k[1] ? 32'($signed(8'((rw >> sh) & 32'hFF))) : rw);
    #1;
    check("R1", "word address", {2'b00, mem_word_addr}, {2'b00, eff[31:2]});
    check("R6", "misalign", {31'h0, misalign}, {31'h0, mis});
    check(k[1] ? "R3" : "R2", "write enable", {31'h0, mem_wr_en}, {31'h0, ewr});
    check(k[1] ? "R3" : "R2", "byte mask", {28'h0, mem_byte_we}, {28'h0, emask});
    check(k[1] ? "R3" : "R2", "write data", mem_wr_data, edata);
    check(k[1] ? "R5" : "R4", "read enable", {31'h0, mem_rd_en}, {31'h0, erd});
    @(posedge clk);
    #1;
    req_valid = 1'b0; mem_rd_data = rw;
    #1;
    check(erd ? "R4" : "R7", "load valid", {31'h0, load_valid}, {31'h0, erd});
    check(k[1] ? "R5" : "R4", "load result", load_result, eres);
  endtask

  initial begin
    logic [31:0] sdat [3];
    logic [31:0] rdat [3];
    sdat[0] = 32'hA1B2_C3F4; sdat[1] = 32'h0102_037F; sdat[2] = 32'hFEDC_BA98;
    rdat[0] = 32'h807F_FF01; rdat[1] = 32'h12F4_56E8; rdat[2] = 32'h7F80_01FE;
    // R8: reset state
    #3;
    check("R8", "load valid in reset", {31'h0, load_valid}, 32'h0);
    check("R8", "load result in reset", load_result, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8", "load valid after reset", {31'h0, load_valid}, 32'h0);
    // R7: idle with a byte store pattern on the bus
    acc_kind = 2'b11; base_addr = 32'h0000_0003; store_data = 32'hFFFF_FFFF;
    #1;
    check("R7", "idle write enable", {31'h0, mem_wr_en}, 32'h0);
    check("R7", "idle mask", {28'h0, mem_byte_we}, 32'h0);
    check("R7", "idle data", mem_wr_data, 32'h0);
    check("R7", "idle read enable", {31'h0, mem_rd_en}, 32'h0);
    acc_kind = 2'b00; base_addr = 32'h0000_0001;
    #1;
    check("R7", "idle misalign", {31'h0, misalign}, 32'h0);
    @(posedge clk); #1;
    check("R7", "idle load valid", {31'h0, load_valid}, 32'h0);
    // sweep: every kind, every offset, three data patterns, positive and negative displacement
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int o = 0; o < 4; o++) begin
          run_access(2'(k), 32'h4000_0100 * (p + 1),
                     16'(o) - 16'(p * 20), sdat[p], rdat[(p + o) % 3]);
        end
      end
    end
    // R1 boundaries: most negative displacement, wraparound past zero
    run_access(2'b10, 32'h0000_9002, 16'h8000, 32'h0, 32'h1122_8344);
    run_access(2'b00, 32'h0000_0004, 16'hFFF8, 32'h0, 32'hCAFE_F00D);
    run_access(2'b01, 32'hFFFF_FFFC, 16'h0008, 32'h5566_7788, 32'h0);
    run_access(2'b11, 32'h7FFF_FFFF, 16'h7FFF, 32'h0000_0080, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule